// File: doc/BRIEF.md
# Retirement Guard Buffer for Redundant Loads

This block sits beside a data cache in a core that runs a program twice, as a leading and a trailing copy, and compares the results. A load in the leading copy reads a cache block, and the trailing copy must later read the same value. The cache therefore must not evict or invalidate that block while any trailing load that targets it is still outstanding. The buffer records each such block address, together with a count of the trailing loads to it that have not yet retired.

A leading load event either claims a free entry for a new block address or raises the count of the entry that already holds that address. A trailing retire event lowers the count, and the entry is released when the count reaches zero. When the cache wants to drop a victim block, it presents the address. In the same cycle the buffer compares it against every entry and answers with either a grant or a defer. When every entry is in use, a full flag tells the leading pipeline to stop issuing loads to new blocks.

Top module: `rload_guard`

## Requirements
- R1: After reset no block is tracked, `full` is low, and a replacement request for any address is granted.
- R2: A leading load to an untracked address, when an entry is free, starts tracking that address with a count of one. A later replacement request for it is deferred.
- R3: A leading load to a tracked address raises its count by one. A replacement of that block stays deferred until the same number of trailing retires have been seen.
- R4: A trailing retire to a tracked address lowers its count by one. When the count reaches zero the entry is released, and a replacement request for that address is granted from the next cycle on.
- R5: A trailing retire to an address that is not tracked changes no state.
- R6: A replacement request is deferred exactly when a tracked entry with a nonzero count matches its address, and is granted otherwise. The answer is combinational and is taken from the state before the clock edge, so a load event in the same cycle does not change it.
- R7: `full` is high exactly when all DEPTH entries are in use. A leading load to a new address while `full` is high is dropped. A leading load to a tracked address is still counted while `full` is high.
- R8: A leading load and a trailing retire to the same tracked address in the same cycle leave its count unchanged.
- R9: The count saturates at 2^CNT_W-1. A further leading load to that address is ignored.
- R10: `repl_grant` and `repl_defer` are low while `repl_vld` is low. Exactly one of them is high while `repl_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lead_vld | input | 1 | Leading-copy load event |
| lead_addr | input | ADDR_W | Block address of the leading load |
| trail_vld | input | 1 | Trailing-copy load retire event |
| trail_addr | input | ADDR_W | Block address of the retiring trailing load |
| repl_vld | input | 1 | Cache asks to replace or invalidate a block |
| repl_addr | input | ADDR_W | Victim block address |
| repl_grant | output | 1 | Replacement may proceed |
| repl_defer | output | 1 | Replacement must wait |
| full | output | 1 | No free entry; stall loads to new blocks |

## Verification
Directed sequences run first. They cover a single load and then its retire, several loads to one block drained one by one, a load and a replacement query in the same cycle, a retire to an untracked block, and a load paired with a retire on one block. These separate the cases of a count that is too high or too low, a query answered from the post-edge state, and retires that wrongly touch other entries. A fill to capacity, followed by loads to a new block and to a tracked block, shows whether the full policy tells the two apart. A burst of more loads than the counter limit exposes missing saturation. A long random mix over a pool larger than the depth then catches interactions that the directed cases do not reach.

// File: rtl/rgb_pkg.sv
// Shared types for the retirement guard buffer.
package rgb_pkg;
    // Per-entry event decode: bit 1 is a retire hit, bit 0 a leading-load hit.
    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_INC  = 2'b01,
        EV_DEC  = 2'b10,
        EV_BOTH = 2'b11
    } ev_e;
endpackage

// File: rtl/rgb_match.sv
// Associative compare of one query address against all entries.
// Assumes at most one valid entry holds any given address.
module rgb_match #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 26
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en_i,
    input  logic [ADDR_W-1:0]             query_i,
    input  logic [DEPTH-1:0]              valid_i,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  addr_i,
    output logic [DEPTH-1:0]              hit_o
);
    // One comparator per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_o[g] = en_i && valid_i[g] && (addr_i[g] == query_i);
    end

    // No address may be tracked twice (R2).
    p_unique_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_o));
endmodule

// File: rtl/rgb_alloc.sv
// Picks the lowest-index free entry for a new address and reports fullness.
// Assumes the request is raised only for addresses that are not tracked.
module rgb_alloc #(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] valid_i,
    input  logic             req_i,
    output logic [DEPTH-1:0] grant_o,
    output logic             full_o
);
    logic [DEPTH-1:0] first_free;
    logic             found;

    // Priority scan for the first free slot.
    always_comb begin
        first_free = '0;
        found      = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!valid_i[i] && !found) begin
                first_free[i] = 1'b1;
                found         = 1'b1;
            end
        end
    end

    // Grant only when requested and a slot exists.
    always_comb begin
        grant_o = (req_i && found) ? first_free : '0;
        full_o  = !found;
    end

    // An allocation never lands on an occupied entry (R7).
    p_alloc_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o & valid_i) == '0) && $onehot0(grant_o));
endmodule

// File: rtl/rgb_entry.sv
// One tracked block: address, valid bit and outstanding-retire count.
// Assumes alloc_i targets only an invalid entry, and inc_i/dec_i only a valid one.
module rgb_entry
    import rgb_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic              inc_i,
    input  logic              dec_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    ev_e ev;
    assign ev = ev_e'({dec_i, inc_i});

    // Entry state update: claim, count up, count down or release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            addr_o  <= '0;
            cnt_o   <= '0;
        end else if (alloc_i) begin
            valid_o <= 1'b1;
            addr_o  <= addr_i;
            cnt_o   <= CNT_ONE;
        end else if (valid_o) begin
            case (ev)
                EV_INC: begin
                    if (cnt_o != CNT_MAX) cnt_o <= cnt_o + CNT_ONE;
                end
                EV_DEC: begin
                    if (cnt_o == CNT_ONE) begin
                        valid_o <= 1'b0;
                        cnt_o   <= '0;
                    end else begin
                        cnt_o <= cnt_o - CNT_ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    p_alloc_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |=> (valid_o && cnt_o == CNT_ONE));
    p_valid_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cnt_o != '0));
    p_pair_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && inc_i && dec_i && !alloc_i) |=> $stable(cnt_o));
    p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cnt_o == CNT_MAX && inc_i && !dec_i) |=> (cnt_o == CNT_MAX));
endmodule

// File: rtl/rload_guard.sv
// Top of the retirement guard buffer. Tracks block addresses with
// outstanding trailing loads and answers cache replacement requests.
// Assumes the leading pipeline stalls new-block loads while full is high.
module rload_guard #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 26,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lead_vld,
    input  logic [ADDR_W-1:0] lead_addr,
    input  logic              trail_vld,
    input  logic [ADDR_W-1:0] trail_addr,
    input  logic              repl_vld,
    input  logic [ADDR_W-1:0] repl_addr,
    output logic              repl_grant,
    output logic              repl_defer,
    output logic              full
);
    logic [DEPTH-1:0]              valid_vec;
    logic [DEPTH-1:0][ADDR_W-1:0]  addr_arr;
    logic [DEPTH-1:0][CNT_W-1:0]   cnt_arr;
    logic [DEPTH-1:0]              lead_hit_vec;
    logic [DEPTH-1:0]              trail_hit_vec;
    logic [DEPTH-1:0]              repl_hit_vec;
    logic [DEPTH-1:0]              busy_vec;
    logic [DEPTH-1:0]              alloc_vec;
    logic                          lead_new;
    logic                          repl_busy;

    rgb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_lead_match (
        .clk(clk), .rst_n(rst_n), .en_i(lead_vld), .query_i(lead_addr),
        .valid_i(valid_vec), .addr_i(addr_arr), .hit_o(lead_hit_vec));

    rgb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_trail_match (
        .clk(clk), .rst_n(rst_n), .en_i(trail_vld), .query_i(trail_addr),
        .valid_i(valid_vec), .addr_i(addr_arr), .hit_o(trail_hit_vec));

    rgb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_repl_match (
        .clk(clk), .rst_n(rst_n), .en_i(repl_vld), .query_i(repl_addr),
        .valid_i(valid_vec), .addr_i(addr_arr), .hit_o(repl_hit_vec));

    // A leading load needs a new entry only when nothing matches.
    assign lead_new = lead_vld && (lead_hit_vec == '0);

    rgb_alloc #(.DEPTH(DEPTH)) u_alloc (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_vec), .req_i(lead_new),
        .grant_o(alloc_vec), .full_o(full));

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        rgb_entry #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ent (
            .clk(clk), .rst_n(rst_n),
            .alloc_i(alloc_vec[g]), .inc_i(lead_hit_vec[g]),
            .dec_i(trail_hit_vec[g]), .addr_i(lead_addr),
            .valid_o(valid_vec[g]), .addr_o(addr_arr[g]), .cnt_o(cnt_arr[g]));
        assign busy_vec[g] = |cnt_arr[g];
    end

    // Replacement answer from the current (pre-edge) state.
    always_comb begin
        repl_busy  = |(repl_hit_vec & busy_vec);
        repl_grant = repl_vld && !repl_busy;
        repl_defer = repl_vld && repl_busy;
    end

    p_resp_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        repl_vld ? (repl_grant ^ repl_defer) : !(repl_grant || repl_defer));
    p_no_alloc_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (alloc_vec == '0));
    p_full_all_used_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full == (valid_vec == '1));
endmodule

// File: tb/test_rload_guard.sv
`timescale 1ns/1ps
module test_rload_guard;
    localparam int DEPTH = 16;
    localparam int AW    = 26;
    localparam int CW    = 4;
    localparam int CMAX  = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lead_vld = 1'b0, trail_vld = 1'b0, repl_vld = 1'b0;
    logic [AW-1:0] lead_addr = '0, trail_addr = '0, repl_addr = '0;
    logic repl_grant, repl_defer, full;

    int errors = 0;
    int checks = 0;
    int ref_cnt[int];

    always #10 clk = ~clk;

    rload_guard #(.DEPTH(DEPTH), .ADDR_W(AW), .CNT_W(CW)) i_rload_guard (
        .clk(clk), .rst_n(rst_n),
        .lead_vld(lead_vld), .lead_addr(lead_addr),
        .trail_vld(trail_vld), .trail_addr(trail_addr),
        .repl_vld(repl_vld), .repl_addr(repl_addr),
        .repl_grant(repl_grant), .repl_defer(repl_defer), .full(full));

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // One cycle: drive, compare outputs with the model, then advance the model.
    task automatic step(input string req, input logic lv, input int la,
                        input logic tv, input int ta, input logic rv, input int ra);
        logic mfull, mbusy, lh, th;
        @(negedge clk);
        lead_vld = lv;  lead_addr = AW'(la);
        trail_vld = tv; trail_addr = AW'(ta);
        repl_vld = rv;  repl_addr = AW'(ra);
        #2;
        mfull = (ref_cnt.num() == DEPTH);
        mbusy = ref_cnt.exists(ra);
        check(req, "full", full, mfull);
        check(req, "repl_grant", repl_grant, rv && !mbusy);
        check(req, "repl_defer", repl_defer, rv && mbusy);
        @(posedge clk);
        lh = lv && ref_cnt.exists(la);
        th = tv && ref_cnt.exists(ta);
        if (th && !(lh && la == ta)) begin
            if (ref_cnt[ta] == 1) ref_cnt.delete(ta);
            else ref_cnt[ta] = ref_cnt[ta] - 1;
        end
        if (lh && !(th && la == ta) && ref_cnt[la] < CMAX)
            ref_cnt[la] = ref_cnt[la] + 1;
        if (lv && !lh && !mfull)
            ref_cnt[la] = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        step("R1", 0, 0, 0, 0, 1, 5);
        step("R1", 0, 0, 0, 0, 1, 'h10);
        // R2: new address tracked, replacement deferred
        step("R2", 1, 'h10, 0, 0, 0, 0);
        step("R2", 0, 0, 0, 0, 1, 'h10);
        // R6: same-cycle load does not affect the answer
        step("R6", 1, 'h20, 0, 0, 1, 'h20);
        step("R6", 0, 0, 0, 0, 1, 'h20);
        // R3: second load, one retire keeps it deferred
        step("R3", 1, 'h10, 0, 0, 0, 0);
        step("R3", 0, 0, 1, 'h10, 1, 'h10);
        step("R3", 0, 0, 0, 0, 1, 'h10);
        // R4: last retire frees the entry
        step("R4", 0, 0, 1, 'h10, 0, 0);
        step("R4", 0, 0, 0, 0, 1, 'h10);
        // R5: retire to an untracked block
        step("R5", 0, 0, 1, 'h99, 0, 0);
        step("R5", 0, 0, 0, 0, 1, 'h20);
        step("R5", 0, 0, 0, 0, 1, 'h99);
        // R8: paired load and retire on one block
        step("R8", 1, 'h20, 1, 'h20, 0, 0);
        step("R8", 0, 0, 1, 'h20, 1, 'h20);
        step("R8", 0, 0, 0, 0, 1, 'h20);
        // R9: more loads than the counter holds
        for (int i = 0; i < CMAX + 2; i++) step("R9", 1, 'h30, 0, 0, 0, 0);
        for (int i = 0; i < CMAX - 1; i++) step("R9", 0, 0, 1, 'h30, 1, 'h30);
        step("R9", 0, 0, 1, 'h30, 1, 'h30);
        step("R9", 0, 0, 0, 0, 1, 'h30);
        // R7: fill, drop a new block, still count a tracked one
        for (int i = 0; i < DEPTH; i++) step("R7", 1, 'h100 + i, 0, 0, 0, 0);
        step("R7", 1, 'h200, 0, 0, 1, 'h100);
        step("R7", 0, 0, 0, 0, 1, 'h200);
        step("R7", 1, 'h101, 1, 'h100, 0, 0);
        step("R7", 1, 'h200, 0, 0, 0, 0);
        step("R7", 0, 0, 1, 'h101, 1, 'h200);
        step("R7", 0, 0, 1, 'h101, 1, 'h101);
        for (int i = 0; i < DEPTH; i++) step("R4", 0, 0, 1, 'h100 + i, 1, 'h100 + i);
        step("R4", 0, 0, 1, 'h200, 1, 'h200);
        // R10: random mix over a pool larger than the depth
        for (int n = 0; n < 6000; n++) begin
            step("R10", ($urandom % 2) == 0, 'h40 + int'($urandom % 24),
                 ($urandom % 5) < 2, 'h40 + int'($urandom % 26),
                 ($urandom % 3) != 0, 'h40 + int'($urandom % 26));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule